// File: doc/BRIEF.md
# DMA Transfer-Control Address Generator

This block takes a 128-bit transfer control block (TCB) on a load strobe and walks a DMA transfer through memory. Each beat presents one 32-bit word address, the operand size and a valid strobe. The consumer accepts a beat by raising `ready_i` and may hold it low to stall. Counts and modifies are always given in 32-bit normal words, whatever the operand size. After each accepted beat the remaining count drops by the number of words in one operand. `done_o` rises once the last beat has been accepted.

At load the TCB is checked against the operand size. The pointer, the modify values and the counts must all keep every access aligned to the operand. A TCB that breaks any of these rules raises `err_o`, and no beat is issued. An optional second dimension adds a row count and a row-end modify. The fourth TCB word, which carries the chaining information, is latched and presented on an output without being acted upon.

Top module: `dma_tcb_addrgen`

## Requirements
- R1: After reset, `valid_o`, `done_o` and `err_o` are all low.
- R2: A legal TCB loaded in cycle k gives `valid_o` high in cycle k+1, with `addr_o` equal to TCB bits 31:0 and `size_o` equal to the operand-size code. TCB bits 127:96 appear on `chain_o` from cycle k+1 onward.
- R3: In one-dimensional mode, each accepted beat moves the address by the X modify (TCB bits 47:32, sign-extended). The transfer runs for X count / operand words beats, where the X count is TCB bits 63:48.
- R4: While `valid_o` is high and `ready_i` is low, the following cycle keeps `valid_o` high and `addr_o` unchanged.
- R5: The cycle after the last beat is accepted, `valid_o` falls and `done_o` rises. `done_o` stays high until the next load.
- R6: The operand-size code sits in TCB bits 97:96 with these values: 0 = normal (1 word), 1 = long (2 words), 2 = quad (4 words). Code 3 is illegal and raises `err_o`.
- R7: An index that is not a multiple of the operand words raises `err_o`, and `valid_o` stays low.
- R8: An X modify that is not a multiple of the operand words raises `err_o`.
- R9: An X count that is zero, or that is not a multiple of the operand words, raises `err_o`.
- R10: TCB bit 98 enables two dimensions, with the Y count in bits 95:80 and the Y modify in bits 79:64. At the end of each row the address moves by the sign-extended Y modify instead of the X modify, and the X count is reloaded. The transfer ends after Y count rows. A zero Y count, or a Y modify that is not a multiple of the operand words, raises `err_o`.
- R11: A load at any time, including during a transfer, restarts the block with the new TCB and clears `done_o` and any earlier `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe for `tcb_i` |
| tcb_i | input | 128 | Transfer control block |
| ready_i | input | 1 | Consumer accepts the current beat |
| addr_o | output | 32 | Word address of the current beat |
| size_o | output | 2 | Operand-size code of the current beat |
| valid_o | output | 1 | Beat is presented |
| done_o | output | 1 | Transfer complete |
| err_o | output | 1 | Loaded TCB was rejected |
| chain_o | output | 32 | Latched fourth TCB word |

## Verification
All outputs come from registers.

- **Load:** the effect of a load, whether the first beat, the error flag or the cleared done, is visible one cycle after the loading edge.
- **Accepted beat:** each accepted beat moves the address one cycle after the edge that took it.
- **Stall:** a stalled beat shows the same address in the next cycle.
- **Completion:** done appears one cycle after the final handshake.

The bench drives inputs and samples outputs on the falling edge. An arithmetic model moves forward one step only after a rising edge with `ready_i` high, so every sample lines up with that single-register latency. The sweep covers:

- all operand sizes;
- index low bits from 0 to 3;
- a range of positive and negative modifies and counts, in both one and two dimensions.

// File: rtl/dma_tcb_pkg.sv
package dma_tcb_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int CHAIN_W = 29;

    typedef enum logic [1:0] {
        OP_NORMAL = 2'd0,
        OP_LONG   = 2'd1,
        OP_QUAD   = 2'd2,
        OP_BAD    = 2'd3
    } op_len_e;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic               two_d;
        op_len_e            op;
    } ctrl_word_t;

    typedef struct packed {
        ctrl_word_t        ctrl;
        logic [CNT_W-1:0]  ycnt;
        logic [CNT_W-1:0]  ymod;
        logic [CNT_W-1:0]  xcnt;
        logic [CNT_W-1:0]  xmod;
        logic [ADDR_W-1:0] index;
    } tcb_t;

    // Low-bit mask that must be clear for an aligned value.
    function automatic logic [1:0] op_mask(op_len_e op);
        case (op)
            OP_NORMAL: return 2'b00;
            OP_LONG:   return 2'b01;
            default:   return 2'b11;
        endcase
    endfunction

    // Number of normal words in one operand.
    function automatic logic [CNT_W-1:0] op_words(op_len_e op);
        case (op)
            OP_NORMAL: return CNT_W'(1);
            OP_LONG:   return CNT_W'(2);
            default:   return CNT_W'(4);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] sext_mod(logic [CNT_W-1:0] m);
        return {{(ADDR_W-CNT_W){m[CNT_W-1]}}, m};
    endfunction

endpackage

// File: rtl/dma_tcb_validate.sv
module dma_tcb_validate
    import dma_tcb_pkg::*;
(
    input  tcb_t tcb,
    output logic legal
);
    logic [1:0] mask;
    logic       bad_op, bad_idx, bad_xmod, bad_xcnt, bad_y;

    always_comb begin
        mask     = op_mask(tcb.ctrl.op);
        // R6
        bad_op   = (tcb.ctrl.op == OP_BAD);
        // R7
        bad_idx  = |(tcb.index[1:0] & mask);
        // R8
        bad_xmod = |(tcb.xmod[1:0] & mask);
        // R9
        bad_xcnt = (tcb.xcnt == '0) || (|(tcb.xcnt[1:0] & mask));
        // R10
        bad_y    = tcb.ctrl.two_d &&
                   ((tcb.ycnt == '0) || (|(tcb.ymod[1:0] & mask)));
        legal    = !(bad_op || bad_idx || bad_xmod || bad_xcnt || bad_y);
    end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_tcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  tcb_t              tcb,
    input  logic              legal,
    input  logic              ready,
    output logic [ADDR_W-1:0] addr,
    output op_len_e           op,
    output logic              valid,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] chain
);
    logic [CNT_W-1:0] xrem, yrem, xcnt_r, xmod_r, ymod_r;
    logic [CNT_W-1:0] step;
    logic             row_end, last_row;

    always_comb begin
        step     = op_words(op);
        row_end  = (xrem == step);
        last_row = (yrem == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            addr   <= '0;
            op     <= OP_NORMAL;
            xrem   <= '0;
            yrem   <= '0;
            xcnt_r <= '0;
            xmod_r <= '0;
            ymod_r <= '0;
            chain  <= '0;
        end else if (load) begin
            valid  <= legal;
            err    <= !legal;
            done   <= 1'b0;
            addr   <= tcb.index;
            op     <= tcb.ctrl.op;
            xrem   <= tcb.xcnt;
            yrem   <= tcb.ctrl.two_d ? tcb.ycnt : CNT_W'(1);
            xcnt_r <= tcb.xcnt;
            xmod_r <= tcb.xmod;
            ymod_r <= tcb.ymod;
            chain  <= tcb.ctrl;
        end else if (valid && ready) begin
            if (row_end) begin
                if (last_row) begin
                    valid <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    addr <= addr + sext_mod(ymod_r);
                    xrem <= xcnt_r;
                    yrem <= yrem - CNT_W'(1);
                end
            end else begin
                addr <= addr + sext_mod(xmod_r);
                xrem <= xrem - step;
            end
        end
    end

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !load) |=> (valid && $stable(addr)));

    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !valid);

    // R5
    done_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(valid && ready && !load));

    // R7
    err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !valid);
endmodule

// File: rtl/dma_tcb_addrgen.sv
module dma_tcb_addrgen
    import dma_tcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [127:0]      tcb_i,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        size_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] chain_o
);
    tcb_t    tcb;
    logic    legal;
    op_len_e op;

    assign tcb    = tcb_t'(tcb_i);
    assign size_o = op;

    dma_tcb_validate i_validate (
        .tcb   (tcb),
        .legal (legal)
    );

    dma_addr_seq i_seq (
        .clk   (clk),
        .rst   (rst),
        .load  (load_i),
        .tcb   (tcb),
        .legal (legal),
        .ready (ready_i),
        .addr  (addr_o),
        .op    (op),
        .valid (valid_o),
        .done  (done_o),
        .err   (err_o),
        .chain (chain_o)
    );

    // R7
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((addr_o[1:0] & op_mask(op_len_e'(size_o))) == 2'b00));

    // R6
    size_legal_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (size_o != 2'd3));
endmodule

// File: tb/test_dma_tcb_addrgen.sv
module test_dma_tcb_addrgen;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [127:0] tcb_i = '0;
    logic         ready_i = 1'b0;
    logic [31:0]  addr_o;
    logic [1:0]   size_o;
    logic         valid_o, done_o, err_o;
    logic [31:0]  chain_o;

    int nchk = 0;
    int nfail = 0;
    int sd = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dma_tcb_addrgen i_dma_tcb_addrgen (
        .clk(clk), .rst(rst), .load_i(load_i), .tcb_i(tcb_i),
        .ready_i(ready_i), .addr_o(addr_o), .size_o(size_o),
        .valid_o(valid_o), .done_o(done_o), .err_o(err_o), .chain_o(chain_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] code, input bit d2, input logic [31:0] idx,
                           input logic [15:0] xc, input logic [15:0] xm,
                           input logic [15:0] yc, input logic [15:0] ym);
        @(negedge clk);
        load_i  = 1'b1;
        ready_i = 1'b0;
        tcb_i   = {29'h0A5A5 ^ {13'b0, idx[15:0]}, d2, code, yc, ym, xc, xm, idx};
        @(negedge clk);
        load_i  = 1'b0;
    endtask

    task automatic run(input logic [1:0] code, input bit d2, input logic [31:0] idx,
                       input logic [15:0] xc, input logic [15:0] xm,
                       input logic [15:0] yc, input logic [15:0] ym);
        int w;
        int rows;
        int per;
        logic [31:0] a;
        logic [1:0] m;
        string tag;
        bit legal;
        w = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
        m = 2'(w - 1);
        tag = "";
        if (code == 2'd3) tag = "R6";
        else if ((idx[1:0] & m) != 0) tag = "R7";
        else if ((xm[1:0] & m) != 0) tag = "R8";
        else if (xc == 0 || (xc[1:0] & m) != 0) tag = "R9";
        else if (d2 && (yc == 0 || (ym[1:0] & m) != 0)) tag = "R10";
        legal = (tag == "");
        do_load(code, d2, idx, xc, xm, yc, ym);
        if (!legal) begin
            chk(err_o === 1'b1, tag, "err_o on bad TCB", 32'(err_o), 32'd1);
            chk(valid_o === 1'b0, tag, "valid_o on bad TCB", 32'(valid_o), 32'd0);
            return;
        end
        chk(err_o === 1'b0, "R2", "err_o on good TCB", 32'(err_o), 32'd0);
        chk(size_o === code, "R2", "size_o", 32'(size_o), 32'(code));
        chk(chain_o[2:0] === {d2, code}, "R2", "chain_o", chain_o, {29'b0, d2, code});
        rows = d2 ? int'(yc) : 1;
        per  = int'(xc) / w;
        a    = idx;
        for (int r = 0; r < rows; r++) begin
            for (int b = 0; b < per; b++) begin
                bit rdy;
                bit stalled;
                stalled = 1'b0;
                do begin
                    rdy = ((sd % 3) != 2);
                    sd++;
                    ready_i = rdy;
                    chk(valid_o === 1'b1, stalled ? "R4" : (d2 ? "R10" : "R3"),
                        "valid_o mid-transfer", 32'(valid_o), 32'd1);
                    chk(addr_o === a, stalled ? "R4" : (d2 ? "R10" : "R3"),
                        "addr_o", addr_o, a);
                    stalled = !rdy;
                    @(negedge clk);
                end while (!rdy);
                if (b == per - 1) a = a + {{16{ym[15]}}, ym};
                else              a = a + {{16{xm[15]}}, xm};
            end
        end
        ready_i = 1'b0;
        chk(valid_o === 1'b0, "R5", "valid_o after last beat", 32'(valid_o), 32'd0);
        chk(done_o === 1'b1, "R5", "done_o after last beat", 32'(done_o), 32'd1);
        @(negedge clk);
        chk(done_o === 1'b1, "R5", "done_o held", 32'(done_o), 32'd1);
    endtask

    logic [15:0] xms [7] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'hFFFC, 16'hFFFE};
    logic [15:0] xcs [6] = '{16'd0, 16'd1, 16'd2, 16'd4, 16'd6, 16'd8};
    logic [15:0] yms [5] = '{16'd0, 16'd2, 16'd4, 16'hFFF8, 16'd1};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(valid_o === 1'b0, "R1", "valid_o after reset", 32'(valid_o), 32'd0);
        chk(done_o === 1'b0, "R1", "done_o after reset", 32'(done_o), 32'd0);
        chk(err_o === 1'b0, "R1", "err_o after reset", 32'(err_o), 32'd0);

        // One-dimensional sweep: R3 R6 R7 R8 R9
        for (int c = 0; c < 4; c++)
            for (int lo = 0; lo < 4; lo++)
                for (int i = 0; i < 7; i++)
                    for (int j = 0; j < 6; j++)
                        run(2'(c), 1'b0, 32'h1000 + 32'(lo), xcs[j], xms[i], 16'd0, 16'd0);

        // Two-dimensional sweep: R10
        for (int c = 0; c < 3; c++)
            for (int y = 0; y < 4; y++)
                for (int k = 0; k < 5; k++)
                    run(2'(c), 1'b1, 32'h2000, 16'(4 << c), 16'(1 << c), 16'(y), yms[k]);

        // R11: restart mid-transfer
        do_load(2'd0, 1'b0, 32'h100, 16'd8, 16'd1, 16'd0, 16'd0);
        ready_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(addr_o === 32'h102, "R11", "addr before restart", addr_o, 32'h102);
        do_load(2'd1, 1'b0, 32'h200, 16'd4, 16'd2, 16'd0, 16'd0);
        chk(addr_o === 32'h200, "R11", "addr after restart", addr_o, 32'h200);
        chk(valid_o === 1'b1, "R11", "valid after restart", 32'(valid_o), 32'd1);
        // R11: error then good load clears err
        do_load(2'd2, 1'b0, 32'h301, 16'd4, 16'd4, 16'd0, 16'd0);
        chk(err_o === 1'b1, "R11", "err set", 32'(err_o), 32'd1);
        do_load(2'd0, 1'b0, 32'h300, 16'd1, 16'd1, 16'd0, 16'd0);
        chk(err_o === 1'b0, "R11", "err cleared", 32'(err_o), 32'd0);
        // R11: done cleared by load
        ready_i = 1'b1;
        @(negedge clk);
        chk(done_o === 1'b1, "R5", "done single beat", 32'(done_o), 32'd1);
        do_load(2'd0, 1'b0, 32'h400, 16'd2, 16'd1, 16'd0, 16'd0);
        chk(done_o === 1'b0, "R11", "done cleared", 32'(done_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule